// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Victim Buffer

This block is a write-back, write-allocate data cache whose main array is direct mapped. Each line holds one data word. A small fully associative buffer sits next to the main array and keeps lines that the main array has recently thrown out. A request that hits the main array is answered in the cycle after it is accepted, just as in a plain direct-mapped cache. A request that misses the main array is then looked up in the buffer. If the buffer holds the line, the buffered line and the conflicting main line trade places, and the answer comes one cycle later. Only when both structures miss does the block go to lower-level memory.

The CPU side accepts one request at a time. The CPU drives `req_valid` with an address, a write flag and write data while `cpu_ready` is high. The block answers with a single-cycle `resp_valid` pulse. The memory side uses a held request with a single-cycle response, and it is used for block reads and for write-backs of dirty lines. Buffer slots are refilled in circular order. A dirty line that is about to be overwritten is written back before the new block is read. Addresses are word addresses. The low `INDEX_W` bits select the main-array line and the remaining bits form the tag.

Top module: `cvb_cache`

## Requirements
- R1: After a synchronous active-low reset, `cpu_ready` is 1, `resp_valid` and `mem_req_valid` are 0, and every line in both structures is invalid, so the first access to any address makes one memory read.
- R2: A request that hits the main array raises `resp_valid` in the cycle after acceptance and causes no memory request.
- R3: A request that misses the main array but hits the buffer raises `resp_valid` two cycles after acceptance, with no memory request. Afterwards the requested line is in the main array and the displaced main line is in the buffer, so two addresses with the same index can alternate without memory traffic.
- R4: A request that misses both structures makes exactly one memory read of its own address. It returns the fetched word on a read, or merges the write data on a write.
- R5: When a fill replaces a valid main line, that line is moved into the buffer, so the next access to it makes no memory read.
- R6: Lines enter the buffer in circular slot order (0, 1, 2, 3, 0, ...). With four slots, the fifth insertion replaces the line inserted first, and the other three stay reachable.
- R7: If the slot about to be overwritten holds a dirty line, exactly one memory write of that line's address and data is made before the fill read. A clean line is dropped without a write.
- R8: A write sets the line dirty and makes no memory write until that line leaves the buffer.
- R9: Once raised, `mem_req_valid`, `mem_req_we` and `mem_req_addr` stay stable until `mem_resp_valid` is sampled.
- R10: Every read returns the last value written to that address since reset, or the memory contents if there was none.
- R11: At most one buffer slot ever matches a given address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | CPU request present; taken when `cpu_ready` is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Block can take a request this cycle |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DATA_W | Read data (write data echoed on writes) |
| mem_req_valid | output | 1 | Memory request, held until the response |
| mem_req_we | output | 1 | 1 = write-back, 0 = block read |
| mem_req_addr | output | ADDR_W | Block address for memory |
| mem_req_wdata | output | DATA_W | Write-back data |
| mem_resp_valid | input | 1 | One-cycle memory completion |
| mem_resp_rdata | input | DATA_W | Block read data |

## Verification
Two addresses that share an index are alternated to show that, after the first two fills, the buffer swap serves them with a two-cycle latency and no memory traffic. Repeated access to one address gives the one-cycle main hit for contrast. A run of six same-index lines, where the first one is written, fills the buffer past its depth. It shows that the circular order decides which line is lost, and that only a dirty line costs a memory write. Random reads and writes over a few conflicting indices are compared against a flat reference memory to catch stale or lost data after swaps.

// File: rtl/cvb_pkg.sv
// Shared types for the victim-buffered cache.
// Assumes: one outstanding CPU request and one outstanding memory request.
package cvb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // take requests, serve main hits
        ST_SWAP = 2'd1,   // exchange buffer line with main line
        ST_WB   = 2'd2,   // write back dirty oldest buffer line
        ST_FILL = 2'd3    // read block from memory
    } cvb_state_e;
endpackage

// File: rtl/cvb_main_array.sv
// Direct-mapped line store: one word per line with valid, dirty and tag.
// Lookup is combinational on lk_addr; one full-line write port.
// Assumes: only valid bits need reset.
module cvb_main_array #(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 32,
    parameter int INDEX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              hit,
    output logic              line_valid,
    output logic              line_dirty,
    output logic [ADDR_W-INDEX_W-1:0] line_tag,
    output logic [DATA_W-1:0] line_data,
    input  logic              wr_en,
    input  logic              wr_dirty,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int LINES = 1 << INDEX_W;
    localparam int TAG_W = ADDR_W - INDEX_W;

    logic [LINES-1:0]  valid_q;
    logic [LINES-1:0]  dirty_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    logic [INDEX_W-1:0] idx;
    logic [TAG_W-1:0]   tag;
    assign idx = lk_addr[INDEX_W-1:0];
    assign tag = lk_addr[ADDR_W-1:INDEX_W];

    // Read out the indexed line and compare its tag.
    always_comb begin
        line_valid = valid_q[idx];
        line_dirty = dirty_q[idx];
        line_tag   = tag_q[idx];
        line_data  = data_q[idx];
        hit        = line_valid && (line_tag == tag);
    end

    // Clear valid bits on reset; write a whole line at the looked-up index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= wr_dirty;
            tag_q[idx]   <= tag;
            data_q[idx]  <= wr_data;
        end
    end
endmodule

// File: rtl/cvb_victim_buf.sv
// Small fully associative store of lines evicted from the main array.
// Each slot keeps the whole block address, data, valid and dirty.
// Inserts go to the slot named by a circular pointer (oldest first);
// swaps overwrite the slot that hit. Assumes swap and insert never coincide.
module cvb_victim_buf #(
    parameter int BLK_W   = 10,
    parameter int DATA_W  = 32,
    parameter int ENTRIES = 4,
    localparam int SEL_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BLK_W-1:0]  lk_blk,
    output logic              hit,
    output logic [SEL_W-1:0]  hit_sel,
    output logic [DATA_W-1:0] hit_data,
    output logic              hit_dirty,
    output logic              old_valid,
    output logic              old_dirty,
    output logic [BLK_W-1:0]  old_blk,
    output logic [DATA_W-1:0] old_data,
    input  logic              swap_en,
    input  logic [SEL_W-1:0]  swap_sel,
    input  logic              ins_en,
    input  logic              in_valid,
    input  logic [BLK_W-1:0]  in_blk,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_dirty
);
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] dirty_q;
    logic [BLK_W-1:0]   blk_q  [ENTRIES];
    logic [DATA_W-1:0]  data_q [ENTRIES];
    logic [SEL_W-1:0]   ptr_q;
    logic [ENTRIES-1:0] match;

    // One comparator per slot.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid_q[g] && (blk_q[g] == lk_blk);
    end

    // Encode the matching slot and expose the oldest slot.
    always_comb begin
        hit_sel = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) hit_sel = SEL_W'(i);
        end
        hit       = |match;
        hit_data  = data_q[hit_sel];
        hit_dirty = dirty_q[hit_sel];
        old_valid = valid_q[ptr_q];
        old_dirty = dirty_q[ptr_q];
        old_blk   = blk_q[ptr_q];
        old_data  = data_q[ptr_q];
    end

    // Slot writes: swap in place, or insert at the pointer and advance it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            ptr_q   <= '0;
        end else if (swap_en || ins_en) begin
            valid_q[swap_en ? swap_sel : ptr_q] <= in_valid;
            dirty_q[swap_en ? swap_sel : ptr_q] <= in_dirty;
            blk_q[swap_en ? swap_sel : ptr_q]   <= in_blk;
            data_q[swap_en ? swap_sel : ptr_q]  <= in_data;
            if (!swap_en) ptr_q <= (ptr_q == SEL_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    // R11: a block is never held twice.
    p_unique_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/cvb_cache.sv
// Direct-mapped write-back cache with a fully associative victim buffer.
// Main hits answer in one cycle; buffer hits swap lines and answer in two;
// double misses write back a dirty oldest buffer line, then fill from memory.
// Assumes: memory holds its response to a single cycle and answers every request.
module cvb_cache
    import cvb_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 32,
    parameter int INDEX_W  = 3,
    parameter int VICTIMS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              cpu_ready,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              mem_req_valid,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_resp_valid,
    input  logic [DATA_W-1:0] mem_resp_rdata
);
    localparam int TAG_W = ADDR_W - INDEX_W;
    localparam int SEL_W = (VICTIMS > 1) ? $clog2(VICTIMS) : 1;

    cvb_state_e        state_q;
    logic              sv_we;
    logic [ADDR_W-1:0] sv_addr;
    logic [DATA_W-1:0] sv_wdata;
    logic [SEL_W-1:0]  sel_q;
    logic [ADDR_W-1:0] lk_addr;

    logic              m_hit, m_valid, m_dirty, m_wr_en, m_wr_dirty;
    logic [TAG_W-1:0]  m_tag;
    logic [DATA_W-1:0] m_data, m_wr_data;

    logic              v_hit, v_hit_dirty, v_old_valid, v_old_dirty;
    logic [SEL_W-1:0]  v_hit_sel;
    logic [DATA_W-1:0] v_hit_data, v_old_data;
    logic [ADDR_W-1:0] v_old_blk;
    logic              v_swap, v_ins;

    assign cpu_ready = (state_q == ST_IDLE);
    assign lk_addr   = cpu_ready ? req_addr : sv_addr;

    cvb_main_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_W(INDEX_W)) u_main (
        .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr),
        .hit(m_hit), .line_valid(m_valid), .line_dirty(m_dirty),
        .line_tag(m_tag), .line_data(m_data),
        .wr_en(m_wr_en), .wr_dirty(m_wr_dirty), .wr_data(m_wr_data)
    );

    cvb_victim_buf #(.BLK_W(ADDR_W), .DATA_W(DATA_W), .ENTRIES(VICTIMS)) u_vict (
        .clk(clk), .rst_n(rst_n), .lk_blk(lk_addr),
        .hit(v_hit), .hit_sel(v_hit_sel), .hit_data(v_hit_data), .hit_dirty(v_hit_dirty),
        .old_valid(v_old_valid), .old_dirty(v_old_dirty), .old_blk(v_old_blk),
        .old_data(v_old_data),
        .swap_en(v_swap), .swap_sel(sel_q), .ins_en(v_ins),
        .in_valid(m_valid), .in_blk({m_tag, lk_addr[INDEX_W-1:0]}),
        .in_data(m_data), .in_dirty(m_dirty)
    );

    // Main-array write port: write hit, swap-in, or fill completion.
    always_comb begin
        m_wr_en    = 1'b0;
        m_wr_dirty = 1'b0;
        m_wr_data  = mem_resp_rdata;
        unique case (state_q)
            ST_IDLE: begin
                m_wr_en    = req_valid && m_hit && req_we;
                m_wr_dirty = 1'b1;
                m_wr_data  = req_wdata;
            end
            ST_SWAP: begin
                m_wr_en    = 1'b1;
                m_wr_dirty = v_hit_dirty || sv_we;
                m_wr_data  = sv_we ? sv_wdata : v_hit_data;
            end
            ST_FILL: begin
                m_wr_en    = mem_resp_valid;
                m_wr_dirty = sv_we;
                m_wr_data  = sv_we ? sv_wdata : mem_resp_rdata;
            end
            default: ;
        endcase
    end

    // Buffer writes: the old main line goes to the hit slot or the oldest slot.
    assign v_swap = (state_q == ST_SWAP);
    assign v_ins  = (state_q == ST_FILL) && mem_resp_valid && m_valid;

    // Memory request: write-back of the oldest slot, else read of the request.
    assign mem_req_valid = (state_q == ST_WB) || (state_q == ST_FILL);
    assign mem_req_we    = (state_q == ST_WB);
    assign mem_req_addr  = (state_q == ST_WB) ? v_old_blk : sv_addr;
    assign mem_req_wdata = v_old_data;

    // Sequence one request through hit, swap, write-back and fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            resp_valid <= 1'b0;
            resp_rdata <= '0;
            sv_we      <= 1'b0;
            sv_addr    <= '0;
            sv_wdata   <= '0;
            sel_q      <= '0;
        end else begin
            resp_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    sv_we    <= req_we;
                    sv_addr  <= req_addr;
                    sv_wdata <= req_wdata;
                    sel_q    <= v_hit_sel;
                    if (m_hit) begin
                        resp_valid <= 1'b1;
                        resp_rdata <= req_we ? req_wdata : m_data;
                    end else if (v_hit) begin
                        state_q <= ST_SWAP;
                    end else if (m_valid && v_old_valid && v_old_dirty) begin
                        state_q <= ST_WB;
                    end else begin
                        state_q <= ST_FILL;
                    end
                end
                ST_SWAP: begin
                    resp_valid <= 1'b1;
                    resp_rdata <= sv_we ? sv_wdata : v_hit_data;
                    state_q    <= ST_IDLE;
                end
                ST_WB: if (mem_resp_valid) state_q <= ST_FILL;
                ST_FILL: if (mem_resp_valid) begin
                    resp_valid <= 1'b1;
                    resp_rdata <= sv_we ? sv_wdata : mem_resp_rdata;
                    state_q    <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2: main hit answers next cycle with no memory traffic.
    p_main_hit_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && req_valid && m_hit) |=> (resp_valid && !mem_req_valid));

    // R3: buffer hit answers one cycle later, never touching memory.
    p_victim_hit_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && req_valid && !m_hit && v_hit) |=>
        (!resp_valid && !mem_req_valid) ##1 (resp_valid && !mem_req_valid));

    // R9: memory request held stable until answered.
    p_mem_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_resp_valid) |=>
        (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));

    // R7: only a dirty, valid oldest slot is ever written back.
    p_wb_dirty_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we) |-> (v_old_valid && v_old_dirty));

    // R4: a fill read targets the captured request address.
    p_fill_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_we) |-> (mem_req_addr == sv_addr));
endmodule

// File: tb/cvb_cache_bench.sv
module cvb_cache_bench;
    localparam int AW  = 10;
    localparam int DW  = 32;
    localparam int IW  = 3;
    localparam int LAT = 4;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          cpu_ready, resp_valid;
    logic [DW-1:0] resp_rdata;
    logic          mem_req_valid, mem_req_we;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata;
    logic          mem_resp_valid = 1'b0;
    logic [DW-1:0] mem_resp_rdata = '0;

    int checks = 0, errors = 0;
    int rd_cnt = 0, wr_cnt = 0;
    bit finished = 0;
    logic [DW-1:0] mem  [WORDS];
    logic [DW-1:0] gold [WORDS];

    always #4 clk = ~clk;   // 125 MHz

    cvb_cache #(.ADDR_W(AW), .DATA_W(DW), .INDEX_W(IW), .VICTIMS(4)) u_cvb_cache (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .cpu_ready(cpu_ready),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_resp_valid(mem_resp_valid), .mem_resp_rdata(mem_resp_rdata)
    );

    function automatic logic [DW-1:0] init_word(input int a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [AW-1:0] mk(input int tag, input int idx);
        return AW'((tag << IW) | idx);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Fixed-latency memory model, driven between clock edges.
    initial begin
        int cnt = 0;
        logic [AW-1:0] first_addr = '0;
        for (int i = 0; i < WORDS; i++) mem[i] = init_word(i);
        forever begin
            @(negedge clk);
            if (mem_req_valid && !mem_resp_valid) begin
                cnt++;
                if (cnt == 1) first_addr = mem_req_addr;
                if (cnt == LAT) begin
                    cnt = 0;
                    chk(mem_req_addr == first_addr, "R9", "held mem address",
                        DW'(mem_req_addr), DW'(first_addr));
                    mem_resp_valid = 1'b1;
                    if (mem_req_we) begin
                        mem[mem_req_addr] = mem_req_wdata;
                        wr_cnt++;
                    end else begin
                        mem_resp_rdata = mem[mem_req_addr];
                        rd_cnt++;
                    end
                end
            end else begin
                mem_resp_valid = 1'b0;
                if (!mem_req_valid) cnt = 0;
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < WORDS; i++) gold[i] = mem[i];
    endtask

    // One access; exp_lat/exp_rd/exp_wr < 0 means not checked.
    task automatic run(input string r, input bit we, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd, input int exp_lat,
                       input int exp_rd, input int exp_wr);
        int r0 = rd_cnt;
        int w0 = wr_cnt;
        int lat;
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!resp_valid) begin @(negedge clk); lat++; end
        if (!we) chk(resp_rdata == gold[a], r, "read data", resp_rdata, gold[a]);
        else gold[a] = wd;
        if (exp_lat >= 0) chk(lat == exp_lat, r, "latency", DW'(lat), DW'(exp_lat));
        if (exp_rd >= 0) chk(rd_cnt - r0 == exp_rd, r, "mem reads", DW'(rd_cnt - r0), DW'(exp_rd));
        if (exp_wr >= 0) chk(wr_cnt - w0 == exp_wr, r, "mem writes", DW'(wr_cnt - w0), DW'(exp_wr));
        if (exp_lat < 0 && lat <= 2)   // R10 random: short answers mean no traffic
            chk((rd_cnt == r0) && (wr_cnt == w0), r, "fast answer without traffic",
                DW'(rd_cnt - r0 + wr_cnt - w0), 0);
    endtask

    initial begin
        logic [AW-1:0] a_addr, b_addr;
        logic [AW-1:0] t [6];
        do_reset();
        @(negedge clk);
        // R1: reset state at the ports
        chk(cpu_ready == 1'b1, "R1", "ready after reset", DW'(cpu_ready), 1);
        chk(resp_valid == 1'b0, "R1", "no response after reset", DW'(resp_valid), 0);
        chk(mem_req_valid == 1'b0, "R1", "no mem request after reset", DW'(mem_req_valid), 0);

        a_addr = mk(1, 0);
        b_addr = mk(2, 0);
        run("R4", 0, a_addr, 0, -1, 1, 0);            // cold miss, one read
        run("R2", 0, a_addr, 0, 1, 0, 0);             // main hit
        run("R8", 1, a_addr, 32'hC0DE_0001, 1, 0, 0); // write hit, no mem write
        run("R2", 0, a_addr, 0, 1, 0, 0);
        run("R5", 0, b_addr, 0, -1, 1, 0);            // A displaced into buffer
        run("R5", 0, a_addr, 0, 2, 0, 0);             // A back without memory
        for (int k = 0; k < 6; k++) begin             // R3 R11 alternation
            run("R3", 0, (k % 2 == 0) ? b_addr : a_addr, 0, 2, 0, 0);
        end

        do_reset();
        run("R1", 0, a_addr, 0, -1, 1, 0);            // reset invalidated all lines

        do_reset();
        for (int k = 0; k < 6; k++) t[k] = mk(k + 1, 1);
        run("R8", 1, t[0], 32'hD1D1_0000, -1, 1, 0);  // write miss: read, no write
        for (int k = 1; k < 5; k++) run("R6", 0, t[k], 0, -1, 1, 0);
        run("R7", 0, t[5], 0, -1, 1, 1);              // dirty oldest written back
        chk(mem[t[0]] == 32'hD1D1_0000, "R7", "write-back data", mem[t[0]], 32'hD1D1_0000);
        run("R7", 0, t[0], 0, -1, 1, 0);              // clean oldest dropped
        run("R6", 0, t[1], 0, -1, 1, 0);              // oldest was replaced
        run("R6", 0, t[4], 0, 2, 0, 0);               // slot 0 still holds t4

        // R10: random mix checked against the flat reference memory
        void'($urandom(32'd2024));
        for (int n = 0; n < 400; n++) begin
            bit we = ($urandom_range(0, 9) < 3);
            logic [AW-1:0] a = AW'($urandom_range(0, 47));
            run("R10", we, a, $urandom, -1, -1, -1);
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule